// File: doc/BRIEF.md
# Framed Command Packet Parser

This block takes one byte per accepted clock from a serial receiver and breaks it into command frames. Each frame opens with a fixed start flag. Next come a tracking identifier, the address of the targeted unit, a command kind (set, query or sort) and a 16-bit payload length, high byte first. The payload follows, then an 8-bit check value and a fixed closing flag. Payload bytes are passed on to a downstream consumer as they arrive, with no buffering.

The header fields appear on their outputs together with a one-cycle completion pulse once the closing flag has been checked. A bad command kind, a check-value mismatch or a wrong closing flag instead gives a one-cycle error pulse with a code, and the parser goes back to hunting for a start flag. While the parser is hunting, bytes other than the start flag are thrown away without any output.

Top module: `cmd_frame_parser`

## Requirements
- R1: After synchronous reset, and again after a reset in the middle of a frame, every output is 0 and the parser waits for a start flag (default 8'hA5).
- R2: While waiting for a start flag, any byte that is not the start flag gives no payload, completion or error output.
- R3: Each payload byte appears on `pay_byte` with `pay_valid` high for one cycle, one clock after it is accepted. Bytes keep their order, and exactly the declared length is forwarded. The length is byte 5 (high) and byte 6 (low) of the frame, counting the start flag as byte 1.
- R4: When a correct closing flag (default 8'h5A) is accepted, `frame_done` pulses for one cycle on the following clock. At that point `frame_id`, `frame_addr`, `frame_type` and `frame_len` show frame bytes 2, 3 and 4 and the length. These outputs then hold until the next good frame.
- R5: A length of 0 is legal. The byte after the length is taken as the check byte, and no payload is forwarded.
- R6: The check byte must equal the CRC-8 (polynomial 0x07, initial value 0x00, MSB first, no final XOR) over every byte from the identifier through the last payload byte. If it does not, the parser pulses `err_pulse` with `err_code`=2 and returns to waiting, with no `frame_done`.
- R7: A command-kind byte other than 1 (set), 2 (query) or 3 (sort) gives `err_pulse` with `err_code`=3 one clock after that byte. The parser then waits again, and none of the frame's later bytes are forwarded.
- R8: A closing byte other than the closing flag gives `err_pulse` with `err_code`=1 and no `frame_done`.
- R9: Cycles with `in_valid` low have no effect on the parse; gaps between bytes are allowed.
- R10: `err_pulse` and `frame_done` never occur in the same cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Received byte |
| pay_valid | output | 1 | Payload byte valid |
| pay_byte | output | 8 | Payload byte |
| frame_done | output | 1 | One-cycle pulse: a good frame has completed |
| frame_id | output | 8 | Tracking identifier of the last good frame |
| frame_addr | output | 8 | Target address of the last good frame |
| frame_type | output | 8 | Command kind of the last good frame |
| frame_len | output | 16 | Payload length of the last good frame |
| err_pulse | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 1 bad closing flag, 2 check mismatch, 3 bad command kind |

## Verification
The bench sends a zero-length frame. A parser that waits for a payload byte there would treat the check byte as payload and then take the closing flag as the check byte.

It sends a 300-byte payload so that the high length byte matters. A design that drops the high byte would end the payload early.

It sends corrupted check and closing bytes and an illegal command kind. It confirms that the header outputs keep the previous good frame, and that the bytes after a kind error are neither forwarded nor allowed to restart a frame.

It also sends noise while idle, inserts gaps between bytes, and resets in the middle of a frame. These catch parsers that react to stray bytes, count idle cycles as data, or carry stale state across a reset.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int LEN_W = 16;

  typedef enum logic [3:0] {
    ST_HUNT, ST_ID, ST_ADDR, ST_KIND, ST_LEN_HI, ST_LEN_LO, ST_BODY, ST_CHECK, ST_CLOSE
  } pstate_t;

  localparam logic [1:0] EC_NONE  = 2'd0;
  localparam logic [1:0] EC_CLOSE = 2'd1;
  localparam logic [1:0] EC_CHECK = 2'd2;
  localparam logic [1:0] EC_KIND  = 2'd3;

  localparam logic [7:0] KIND_SET   = 8'd1;
  localparam logic [7:0] KIND_QUERY = 8'd2;
  localparam logic [7:0] KIND_SORT  = 8'd3;

  function automatic logic kind_ok(input logic [7:0] k);
    return (k == KIND_SET) || (k == KIND_QUERY) || (k == KIND_SORT);
  endfunction
endpackage

// File: rtl/cfp_crc8.sv
module cfp_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  logic [7:0] nxt;

  always_comb begin
    nxt = crc ^ din;
    for (int i = 0; i < 8; i++) begin
      nxt = nxt[7] ? ((nxt << 1) ^ POLY) : (nxt << 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= 8'h00;
    else if (en)    crc <= nxt;
  end
endmodule

// File: rtl/cfp_len_cnt.sv
module cfp_len_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)       remain <= '0;
    else if (load) remain <= load_val;
    else if (dec)  remain <= remain - 1'b1;
  end

  assign last = (remain == {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser #(
  parameter logic [7:0] SOF_VAL  = 8'hA5,
  parameter logic [7:0] EOF_VAL  = 8'h5A,
  parameter logic [7:0] CRC_POLY = 8'h07
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        pay_valid,
  output logic [7:0]  pay_byte,
  output logic        frame_done,
  output logic [7:0]  frame_id,
  output logic [7:0]  frame_addr,
  output logic [7:0]  frame_type,
  output logic [15:0] frame_len,
  output logic        err_pulse,
  output logic [1:0]  err_code
);
  import cfp_pkg::*;

  pstate_t          st;
  logic [7:0]       h_id, h_addr, h_kind, h_len_hi;
  logic [LEN_W-1:0] h_len;
  logic [7:0]       crc_q;
  logic             cnt_last;
  logic             crc_clr, crc_en, cnt_load, cnt_dec;
  logic [LEN_W-1:0] len_full;

  assign len_full = {h_len_hi, in_byte};
  assign crc_clr  = in_valid && (st == ST_HUNT);
  assign crc_en   = in_valid && (st inside {ST_ID, ST_ADDR, ST_KIND, ST_LEN_HI, ST_LEN_LO, ST_BODY});
  assign cnt_load = in_valid && (st == ST_LEN_LO);
  assign cnt_dec  = in_valid && (st == ST_BODY);

  cfp_crc8 #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(in_byte), .crc(crc_q)
  );

  cfp_len_cnt #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(len_full), .dec(cnt_dec), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HUNT;
      h_id       <= '0;
      h_addr     <= '0;
      h_kind     <= '0;
      h_len_hi   <= '0;
      h_len      <= '0;
      pay_valid  <= 1'b0;
      pay_byte   <= '0;
      frame_done <= 1'b0;
      frame_id   <= '0;
      frame_addr <= '0;
      frame_type <= '0;
      frame_len  <= '0;
      err_pulse  <= 1'b0;
      err_code   <= EC_NONE;
    end else begin
      pay_valid  <= 1'b0;
      frame_done <= 1'b0;
      err_pulse  <= 1'b0;
      err_code   <= EC_NONE;
      if (in_valid) begin
        case (st)
          ST_HUNT:   if (in_byte == SOF_VAL) st <= ST_ID;
          ST_ID:     begin h_id <= in_byte;   st <= ST_ADDR; end
          ST_ADDR:   begin h_addr <= in_byte; st <= ST_KIND; end
          ST_KIND: begin
            if (kind_ok(in_byte)) begin
              h_kind <= in_byte;
              st     <= ST_LEN_HI;
            end else begin
              err_pulse <= 1'b1;
              err_code  <= EC_KIND;
              st        <= ST_HUNT;
            end
          end
          ST_LEN_HI: begin h_len_hi <= in_byte; st <= ST_LEN_LO; end
          ST_LEN_LO: begin
            h_len <= len_full;
            st    <= (len_full == '0) ? ST_CHECK : ST_BODY;
          end
          ST_BODY: begin
            pay_valid <= 1'b1;
            pay_byte  <= in_byte;
            if (cnt_last) st <= ST_CHECK;
          end
          ST_CHECK: begin
            if (in_byte == crc_q) st <= ST_CLOSE;
            else begin
              err_pulse <= 1'b1;
              err_code  <= EC_CHECK;
              st        <= ST_HUNT;
            end
          end
          ST_CLOSE: begin
            if (in_byte == EOF_VAL) begin
              frame_done <= 1'b1;
              frame_id   <= h_id;
              frame_addr <= h_addr;
              frame_type <= h_kind;
              frame_len  <= h_len;
            end else begin
              err_pulse <= 1'b1;
              err_code  <= EC_CLOSE;
            end
            st <= ST_HUNT;
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        pay_valid,
  input logic        frame_done,
  input logic [7:0]  frame_id,
  input logic [15:0] frame_len,
  input logic        err_pulse,
  input logic [1:0]  err_code
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) frame_done |=> !frame_done); // R4
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_done |-> ($stable(frame_id) && $stable(frame_len))); // R4
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) err_pulse |=> !err_pulse); // R10
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(frame_done && err_pulse)); // R10
  AST_ERR_CODE_SET: assert property (@(posedge clk) disable iff (rst) err_pulse |-> (err_code != 2'd0)); // R6
  AST_PAY_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst) pay_valid |-> $past(in_valid)); // R9
  AST_DONE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst) frame_done |-> $past(in_valid)); // R9
  AST_NO_PAY_AT_DONE: assert property (@(posedge clk) disable iff (rst) frame_done |-> !pay_valid); // R3
endmodule

bind cmd_frame_parser cfp_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pay_valid(pay_valid), .frame_done(frame_done),
  .frame_id(frame_id), .frame_len(frame_len), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/sim_cmd_frame_parser.sv
`timescale 1ns/1ps
module sim_cmd_frame_parser;
  localparam logic [7:0] SOF = 8'hA5;
  localparam logic [7:0] EOF = 8'h5A;

  typedef struct packed {
    logic [7:0]  id;
    logic [7:0]  addr;
    logic [7:0]  kind;
    logic [15:0] len;
    logic [31:0] pay;
    logic        crc_bad;
    logic        eof_bad;
    logic [1:0]  exp_err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [0:NV-1] = '{
    '{8'h11, 8'h20, 8'h01, 16'd3, 32'h00CCBBAA, 1'b0, 1'b0, 2'd0},
    '{8'h12, 8'h21, 8'h02, 16'd1, 32'h0000007F, 1'b0, 1'b0, 2'd0},
    '{8'h13, 8'h22, 8'h03, 16'd4, 32'h44332211, 1'b1, 1'b0, 2'd2},
    '{8'h14, 8'h23, 8'h02, 16'd2, 32'h0000EEDD, 1'b0, 1'b1, 2'd1},
    '{8'h15, 8'h24, 8'h07, 16'd2, 32'h00001234, 1'b0, 1'b0, 2'd3},
    '{8'h16, 8'h25, 8'h01, 16'd0, 32'h00000000, 1'b0, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        pay_valid, frame_done, err_pulse;
  logic [7:0]  pay_byte, frame_id, frame_addr, frame_type;
  logic [15:0] frame_len;
  logic [1:0]  err_code;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] exp_pay [0:511];
  logic [7:0] rx_pay  [0:511];
  int rx_n = 0, done_n = 0, err_n = 0;
  logic [1:0] last_err = 2'd0;
  logic [7:0] good_id = 8'h00;
  logic [15:0] good_len = 16'h0000;

  always #4 clk = ~clk;

  cmd_frame_parser u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .pay_valid(pay_valid), .pay_byte(pay_byte), .frame_done(frame_done),
    .frame_id(frame_id), .frame_addr(frame_addr), .frame_type(frame_type),
    .frame_len(frame_len), .err_pulse(err_pulse), .err_code(err_code)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (pay_valid) begin
        if (rx_n < 512) rx_pay[rx_n] = pay_byte;
        rx_n++;
      end
      if (frame_done) done_n++;
      if (err_pulse) begin err_n++; last_err = err_code; end
    end
  end

  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_n = 0; done_n = 0; err_n = 0; last_err = 2'd0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // payload taken from exp_pay[0..len-1]; full=0 stops after payload
  task automatic send_frame(input logic [7:0] id, input logic [7:0] addr, input logic [7:0] kind,
                            input logic [15:0] len, input bit crc_bad, input bit eof_bad,
                            input bit full, input int gap);
    logic [7:0] c;
    c = 8'h00;
    send_byte(SOF, gap);
    send_byte(id, gap);   c = crc_ref(c, id);
    send_byte(addr, gap); c = crc_ref(c, addr);
    send_byte(kind, gap); c = crc_ref(c, kind);
    send_byte(len[15:8], gap); c = crc_ref(c, len[15:8]);
    send_byte(len[7:0], gap);  c = crc_ref(c, len[7:0]);
    for (int i = 0; i < int'(len); i++) begin
      send_byte(exp_pay[i], gap);
      c = crc_ref(c, exp_pay[i]);
    end
    if (full) begin
      send_byte(crc_bad ? (c ^ 8'hFF) : c, gap);
      send_byte(eof_bad ? (EOF ^ 8'h0F) : EOF, gap);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_payload(input int len, input string req);
    bit same;
    same = (rx_n == len);
    for (int i = 0; i < len && i < 512; i++) if (rx_pay[i] !== exp_pay[i]) same = 1'b0;
    chk(same, req, rx_n, len);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk({pay_valid, frame_done, err_pulse, err_code, frame_id, frame_len} == '0,
        "R1 outputs zero after reset", {frame_id, frame_len}, 0);

    // R2: idle noise ignored
    clear_mon();
    send_byte(8'h00, 0); send_byte(EOF, 0); send_byte(8'hFF, 1); send_byte(8'h13, 0);
    repeat (2) @(negedge clk);
    chk(rx_n == 0 && done_n == 0 && err_n == 0, "R2 idle noise produced output", rx_n + done_n + err_n, 0);

    // table of vectors
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      for (int i = 0; i < 4; i++) exp_pay[i] = v.pay[8*i +: 8];
      clear_mon();
      send_frame(v.id, v.addr, v.kind, v.len, v.crc_bad, v.eof_bad, v.exp_err != 2'd3, 0);
      if (v.exp_err == 2'd0) begin
        chk(done_n == 1 && err_n == 0, "R4 R6 good frame completes", done_n, 1);
        chk(frame_id == v.id && frame_addr == v.addr && frame_type == v.kind && frame_len == v.len,
            "R4 header fields", {frame_id, frame_addr, frame_type, frame_len},
            {v.id, v.addr, v.kind, v.len});
        check_payload(int'(v.len), v.len == 0 ? "R5 zero-length payload" : "R3 payload bytes");
        good_id = v.id; good_len = v.len;
      end else begin
        chk(done_n == 0 && err_n == 1 && last_err == v.exp_err,
            v.exp_err == 2'd2 ? "R6 check mismatch code" : (v.exp_err == 2'd1 ? "R8 bad close code" : "R7 bad kind code"),
            {done_n[7:0], err_n[7:0], 6'd0, last_err}, {8'd0, 8'd1, 6'd0, v.exp_err});
        chk(frame_id == good_id && frame_len == good_len, "R4 header held after error",
            {frame_id, frame_len}, {good_id, good_len});
        check_payload(v.exp_err == 2'd3 ? 0 : int'(v.len),
                      v.exp_err == 2'd3 ? "R7 no payload after bad kind" : "R3 payload before late error");
      end
    end

    // R9: gaps between bytes
    exp_pay[0] = 8'h01; exp_pay[1] = SOF; exp_pay[2] = EOF;
    clear_mon();
    send_frame(8'h31, 8'h41, 8'h03, 16'd3, 1'b0, 1'b0, 1'b1, 2);
    chk(done_n == 1 && err_n == 0 && frame_id == 8'h31, "R9 frame with idle gaps", frame_id, 8'h31);
    check_payload(3, "R9 payload with gaps");

    // R3: long payload uses both length bytes
    for (int i = 0; i < 300; i++) exp_pay[i] = 8'((i * 7 + 3) & 255);
    clear_mon();
    send_frame(8'h32, 8'h42, 8'h02, 16'd300, 1'b0, 1'b0, 1'b1, 0);
    chk(done_n == 1 && frame_len == 16'd300, "R3 300-byte frame length", frame_len, 300);
    check_payload(300, "R3 300-byte payload");

    // R1: reset in the middle of a frame
    send_byte(SOF, 0); send_byte(8'h50, 0); send_byte(8'h51, 0); send_byte(8'h01, 0);
    send_byte(8'h00, 0); send_byte(8'h05, 0); send_byte(8'h99, 0);
    do_reset();
    chk({pay_valid, frame_done, err_pulse, frame_id, frame_len} == '0, "R1 mid-frame reset clears",
        {frame_id, frame_len}, 0);
    exp_pay[0] = 8'hC3;
    clear_mon();
    send_frame(8'h33, 8'h43, 8'h01, 16'd1, 1'b0, 1'b0, 1'b1, 0);
    chk(done_n == 1 && err_n == 0 && frame_id == 8'h33, "R1 parse after mid-frame reset", frame_id, 8'h33);
    chk(err_n == 0, "R10 no spurious error", err_n, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule